// File: doc/BRIEF.md
# Array-Based Queue Lock Unit

This block arbitrates one shared resource among a power-of-two number of requesters. Ownership passes in strict arrival order. Internally it keeps a ring of per-slot flags, each either WAIT or ENTER, and a tail counter that hands out ring slots as tickets. A requester that asks for the lock takes the current tail value as its ticket, and the tail advances. The requester then watches only its own slot flag. When that flag shows ENTER, the requester becomes the holder and puts the flag back to WAIT, so the slot is ready for its next use one lap later. When the holder lets go, it raises ENTER on the slot after its own. Only the next ticket in line sees that change.

Each requester has a plain control interface. A one-cycle acquire pulse enters the queue and a one-cycle release pulse gives the lock up. A level output stays high for as long as that requester holds the lock. No data moves through the block, so no valid/ready pair exists and no back-pressure applies. An acquire that the block does not accept is simply dropped, and the requester may pulse again once it is idle. Because every requester owns at most one ticket, no more than N tickets are ever outstanding, and the ring of N slots cannot overflow.

Top module: `aqlock_unit`

## Requirements
- R1: After reset all grant outputs are 0, the tail is 0, slot 0 holds ENTER (flag value 1) and every other slot holds WAIT (flag value 0). A first acquire pulse after reset is granted on the second rising edge after the pulse.
- R2: An acquire pulse from an idle requester takes the current tail value as its slot and advances the tail by one. The tail wraps modulo N, so a slot number is always a flag index.
- R3: Acquire pulses that arrive in the same cycle take consecutive slots, with the lowest requester index taking the current tail.
- R4: A waiting requester becomes holder on the rising edge that follows a cycle in which its slot flag is ENTER, and it is never granted while that flag is WAIT. Grant output bit k belongs to requester k.
- R5: On being granted, the holder's slot flag returns to WAIT. A requester that later gets the same slot number waits until a release sets it again.
- R6: A release pulse from the holder clears its grant on the next edge and sets ENTER on slot (own slot + 1) mod N. The waiter holding that slot is granted one edge later.
- R7: At most one grant output is high at any time, and grants follow the order in which slots were taken.
- R8: A release pulse from a requester that does not hold the lock is ignored. An acquire pulse from a requester that is already waiting or holding is ignored and takes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_i | input | N_REQ | Per-requester one-cycle acquire pulse |
| rel_i | input | N_REQ | Per-requester one-cycle release pulse |
| granted_o | output | N_REQ | Per-requester holder indication, high while held |

## Verification
The bench first applies staggered single acquires, so that slots are taken out of requester-index order. This separates first-come-first-served behaviour from a fixed-priority scheme. An acquire arriving together with a duplicate acquire from the current holder, and stray releases from waiting requesters, show whether any unaccepted pulse leaks into the tail or the flag ring. A full lap that reuses slot 0 tells a cleared flag apart from a stale ENTER. All four requesters acquiring in one cycle with a nonzero tail checks the ascending-index ordering and the wrap of the tail. A reset in the middle of a run, with a waiter pending, shows that flags and tail return to their initial state.

// File: rtl/aqlock_pkg.sv
package aqlock_pkg;

  // Per-slot flag encoding
  localparam logic FLAG_WAIT  = 1'b0;
  localparam logic FLAG_ENTER = 1'b1;

  // Requester-side state
  typedef enum logic [1:0] {
    RQ_IDLE = 2'd0,
    RQ_WAIT = 2'd1,
    RQ_HOLD = 2'd2
  } rq_state_t;

endpackage

// File: rtl/aqlock_ticket_alloc.sv
module aqlock_ticket_alloc #(
  parameter int N_REQ = 4,
  localparam int SW   = $clog2(N_REQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_REQ-1:0]          take_i,
  output logic [N_REQ-1:0][SW-1:0]  slot_o
);

  logic [SW-1:0] tail_q;
  logic [SW-1:0] tail_d;

  // Ascending requester index takes consecutive tickets (R3)
  always_comb begin
    logic [SW-1:0] run;
    run = tail_q;
    for (int k = 0; k < N_REQ; k++) begin
      slot_o[k] = run;
      if (take_i[k]) run = run + SW'(1);
    end
    tail_d = run;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tail_q <= '0;
    else        tail_q <= tail_d;
  end

  // R2: the tail only moves when some ticket is taken
  a_r2_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i == '0) |=> (tail_q == $past(tail_q)));

endmodule

// File: rtl/aqlock_flag_array.sv
module aqlock_flag_array #(
  parameter int N_REQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] clr_i,
  input  logic [N_REQ-1:0] set_i,
  output logic [N_REQ-1:0] flag_o
);

  logic [N_REQ-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= N_REQ'(1);
    else        flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;

  // R1: never more than one slot open at once
  a_r1_single_enter: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flag_q) <= 1);

  // R5: a flag consumed by a grant reads WAIT afterwards
  a_r5_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i != '0) && ((clr_i & set_i) == '0)) |=> ((flag_q & $past(clr_i)) == '0));

endmodule

// File: rtl/aqlock_requester.sv
module aqlock_requester
  import aqlock_pkg::*;
#(
  parameter int N_REQ = 4,
  localparam int SW   = $clog2(N_REQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_i,
  input  logic             rel_i,
  input  logic [SW-1:0]    slot_i,
  input  logic [N_REQ-1:0] flags_i,
  output logic             take_o,
  output logic             granted_o,
  output logic [N_REQ-1:0] clr_o,
  output logic [N_REQ-1:0] set_o
);

  rq_state_t     st_q;
  logic [SW-1:0] slot_q;
  logic          my_flag;
  logic          enter_ok;
  logic          rel_ok;
  logic [SW-1:0] next_slot;

  assign my_flag   = flags_i[slot_q];
  assign take_o    = acq_i && (st_q == RQ_IDLE);
  assign enter_ok  = (st_q == RQ_WAIT) && (my_flag == FLAG_ENTER);
  assign rel_ok    = rel_i && (st_q == RQ_HOLD);
  assign next_slot = slot_q + SW'(1);
  assign granted_o = (st_q == RQ_HOLD);

  always_comb begin
    clr_o = '0;
    set_o = '0;
    if (enter_ok) clr_o[slot_q]    = 1'b1;
    if (rel_ok)   set_o[next_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RQ_IDLE;
      slot_q <= '0;
    end else begin
      unique case (st_q)
        RQ_IDLE: if (take_o) begin
          st_q   <= RQ_WAIT;
          slot_q <= slot_i;
        end
        RQ_WAIT: if (enter_ok) st_q <= RQ_HOLD;
        RQ_HOLD: if (rel_ok)   st_q <= RQ_IDLE;
        default: st_q <= RQ_IDLE;
      endcase
    end
  end

  // R4: a closed slot never yields a grant
  a_r4_needs_enter: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == RQ_WAIT) && (flags_i[slot_q] == FLAG_WAIT)) |=> (st_q != RQ_HOLD));

  // R6: a holder's release ends its grant on the next edge
  a_r6_release_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_i && granted_o) |=> !granted_o);

  // R8: an acquire while busy keeps the slot unchanged
  a_r8_acq_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_i && (st_q != RQ_IDLE)) |=> (slot_q == $past(slot_q)));

endmodule

// File: rtl/aqlock_unit.sv
module aqlock_unit #(
  parameter int N_REQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] acq_i,
  input  logic [N_REQ-1:0] rel_i,
  output logic [N_REQ-1:0] granted_o
);

  localparam int SW = $clog2(N_REQ);

  logic [N_REQ-1:0]           take;
  logic [N_REQ-1:0][SW-1:0]   slot;
  logic [N_REQ-1:0]           flags;
  logic [N_REQ-1:0][N_REQ-1:0] clr_each;
  logic [N_REQ-1:0][N_REQ-1:0] set_each;
  logic [N_REQ-1:0]           clr_all;
  logic [N_REQ-1:0]           set_all;

  aqlock_ticket_alloc #(.N_REQ(N_REQ)) u_alloc (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take),
    .slot_o (slot)
  );

  aqlock_flag_array #(.N_REQ(N_REQ)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_all),
    .set_i  (set_all),
    .flag_o (flags)
  );

  for (genvar k = 0; k < N_REQ; k++) begin : g_rq
    aqlock_requester #(.N_REQ(N_REQ)) u_rq (
      .clk       (clk),
      .rst_n     (rst_n),
      .acq_i     (acq_i[k]),
      .rel_i     (rel_i[k]),
      .slot_i    (slot[k]),
      .flags_i   (flags),
      .take_o    (take[k]),
      .granted_o (granted_o[k]),
      .clr_o     (clr_each[k]),
      .set_o     (set_each[k])
    );
  end

  always_comb begin
    clr_all = '0;
    set_all = '0;
    for (int k = 0; k < N_REQ; k++) begin
      clr_all = clr_all | clr_each[k];
      set_all = set_all | set_each[k];
    end
  end

  // R7: exclusive ownership
  a_r7_one_holder: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(granted_o));

endmodule

// File: tb/aqlock_unit_bench.sv
module aqlock_unit_bench;

  localparam int N = 4;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] acq;
  logic [N-1:0] rel;
  logic [N-1:0] granted;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aqlock_unit #(.N_REQ(N)) u_aqlock_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_i     (acq),
    .rel_i     (rel),
    .granted_o (granted)
  );

  // Row = {acq, rel, expected grant after one edge}
  localparam int ROWS = 19;
  localparam logic [11:0] VEC [ROWS] = '{
    {4'b0001, 4'b0000, 4'b0000},  // r0 takes slot 0
    {4'b0000, 4'b0000, 4'b0001},  // r0 granted
    {4'b1010, 4'b0000, 4'b0001},  // r1 slot1, r3 slot2
    {4'b0100, 4'b0000, 4'b0001},  // r2 slot3
    {4'b0000, 4'b0010, 4'b0001},  // stray release by waiter r1
    {4'b0000, 4'b0001, 4'b0000},  // r0 releases
    {4'b0000, 4'b0000, 4'b0010},  // r1 granted
    {4'b0011, 4'b0000, 4'b0010},  // r0 slot0 (lap), r1 dup ignored
    {4'b0000, 4'b0010, 4'b0000},  // r1 releases
    {4'b0000, 4'b0000, 4'b1000},  // r3 before r2 (arrival order)
    {4'b0000, 4'b1000, 4'b0000},
    {4'b0000, 4'b0000, 4'b0100},  // r2
    {4'b0000, 4'b0100, 4'b0000},
    {4'b0000, 4'b0000, 4'b0001},  // r0 reused slot0
    {4'b0000, 4'b0001, 4'b0000},
    {4'b0000, 4'b0000, 4'b0000},  // idle, slot1 open
    {4'b0100, 4'b0000, 4'b0000},  // r2 slot1
    {4'b0000, 4'b0000, 4'b0100},
    {4'b0000, 4'b0100, 4'b0000}   // tail now 2, slot2 open
  };

  task automatic step(input logic [N-1:0] a, input logic [N-1:0] r);
    acq = a;
    rel = r;
    @(negedge clk);
    acq = '0;
    rel = '0;
  endtask

  task automatic chk(input logic [N-1:0] exp, input string tag);
    total++;
    if (granted !== exp) begin
      fails++;
      $display("FAIL %s granted=%b expected=%b", tag, granted, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired granted=%b expected=done", granted);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    acq   = '0;
    rel   = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(4'b0000, "R1 reset grants low");
    rst_n = 1'b1;
    @(negedge clk);
    chk(4'b0000, "R1 idle after reset");

    // Table walk: R2 R4 R5 R6 R7 R8
    for (int i = 0; i < ROWS; i++) begin
      step(VEC[i][11:8], VEC[i][7:4]);
      chk(VEC[i][3:0], $sformatf("R2/R4/R5/R6/R7/R8 table row %0d", i));
    end

    // R3: all four at once with tail=2 -> r0:2 r1:3 r2:0 r3:1
    step(4'b1111, 4'b0000);
    chk(4'b0000, "R3 simultaneous acquire, not yet granted");
    step(4'b0000, 4'b0000);
    chk(4'b0001, "R3 r0 first (slot2)");
    step(4'b0000, 4'b1000);
    chk(4'b0001, "R8 release by waiter r3 ignored");
    step(4'b0001, 4'b0000);
    chk(4'b0001, "R8 acquire by holder ignored");
    step(4'b0000, 4'b0001);
    chk(4'b0000, "R6 release clears grant");
    step(4'b0000, 4'b0000);
    chk(4'b0010, "R3 r1 second (slot3)");
    step(4'b0000, 4'b0010);
    step(4'b0000, 4'b0000);
    chk(4'b0100, "R3 r2 third (slot0 after wrap)");
    step(4'b0000, 4'b0100);
    step(4'b0000, 4'b0000);
    chk(4'b1000, "R3 r3 last (slot1)");

    // R1: reset mid-run with a pending waiter
    step(4'b0001, 4'b0000);
    rst_n = 1'b0;
    @(negedge clk);
    chk(4'b0000, "R1 reset drops holder");
    rst_n = 1'b1;
    step(4'b0000, 4'b0000);
    chk(4'b0000, "R1 no stale waiter after reset");
    step(4'b0100, 4'b0000);
    chk(4'b0000, "R1 first acquire after reset, one edge");
    step(4'b0000, 4'b0000);
    chk(4'b0100, "R1 first acquire granted on second edge");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule